// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Postponement Credit

This block decides when a DDR3-style memory controller must send auto-refresh commands. A free-running interval timer adds one unit of refresh debt each average refresh interval. Each REFRESH actually sent pays back one unit. Refreshes do not fire on a fixed beat. The command arbiter may put them off while traffic is heavy, up to a bounded number of postponed units. After that bound the block raises an urgent flag, and the arbiter must stop taking new accesses until the debt is paid down.

The exchange with the arbiter is a request/grant pair. The block raises a request. The arbiter closes every open row, then asserts grant to say all banks are precharged. In that cycle the block emits a one-cycle REFRESH strobe. The strobe carries no address, because the device steps its own row counter. The block then holds a busy window covering the refresh recovery time, during which no other command may be sent. A pacing counter spaces successive refreshes so that at most the allowed burst count can fall in any window of two refresh intervals. This bounds how fast a backlog is repaid.

The interval length follows a temperature-range select: the extended range halves the interval. Intervals, recovery time and limits are all given in clock cycles as parameters.

Top module: `dram_refresh_planner`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, refReq, refUrgent, refIssue and rfcBusy are all 0.
- R2: With hotMode=0 the debt grows by one every REFI_NORM_CYC cycles. After release from reset with arbIdle=1, refReq first reads 1 exactly REFI_NORM_CYC+1 clock edges after release.
- R3: With hotMode=1 the interval is REFI_HOT_CYC cycles. refReq first reads 1 exactly REFI_HOT_CYC+1 edges after release with arbIdle=1.
- R4: While arbIdle=1 a request is raised as soon as debt is at least 1. While arbIdle=0 a request is raised only when debt is at least BUSY_REQ_LVL, or when urgent. With arbIdle=0 and BUSY_REQ_LVL=3, refReq is 0 at edge 3*REFI_NORM_CYC and 1 at the next edge.
- R5: Once raised, refReq stays 1 until refGrant is 1. refIssue is 1 only in a cycle where refReq and refGrant are both 1, and refReq reads 0 after the edge that takes the refresh. refGrant while refReq is 0 produces no refIssue.
- R6: After each REFRESH edge, rfcBusy is 1 for exactly RFC_CYC cycles, and no refIssue occurs while rfcBusy is 1.
- R7: Two REFRESH edges are never closer than ceil(2*tREFI/BURST_LIMIT) cycles, using the interval of the current mode.
- R8: refUrgent is 1 exactly when debt is at least MAX_POSTPONE. With no grants it rises at edge MAX_POSTPONE*REFI_NORM_CYC, and it clears after the next REFRESH.
- R9: Debt saturates at MAX_POSTPONE+1 and never wraps. Each REFRESH lowers it by one. If a tick and a REFRESH fall in the same cycle, the debt is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hotMode | input | 1 | 1 selects the extended-temperature (short) refresh interval |
| arbIdle | input | 1 | Arbiter hint: 1 when there is no pending traffic |
| refGrant | input | 1 | Arbiter: all banks precharged, refresh may go now |
| refReq | output | 1 | Refresh request to the arbiter |
| refUrgent | output | 1 | Postponement limit reached; arbiter must stop new accesses |
| refIssue | output | 1 | One-cycle REFRESH command strobe |
| rfcBusy | output | 1 | Refresh recovery window; no other command allowed |

## Verification
Some properties are checked by assertions on every cycle:
- no REFRESH while the recovery window is open;
- no REFRESH without debt;
- no REFRESH before the pacing counter has expired;
- a request is held until it is granted;
- debt never climbs by more than one per cycle.

Other behaviour can only be shown by the bench's directed scenarios:
- the exact interval lengths in both temperature modes;
- the busy-versus-idle request levels;
- the cycle at which urgency rises and clears;
- the total number of refreshes repaid from a saturated backlog, which proves saturation rather than wrap.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic issue;      // REFRESH taken this cycle
  } rfshStrobe_t;

  // Status from datapath to control
  typedef struct packed {
    logic debtAny;    // debt >= 1
    logic debtBusy;   // debt >= busy request level
    logic urgent;     // debt >= postponement limit
    logic paceOk;     // pacing spacing satisfied
    logic rfcIdle;    // recovery window closed
  } rfshStatus_t;

  typedef enum logic [0:0] {
    ST_WAIT = 1'b0,
    ST_REQ  = 1'b1
  } rfshState_t;

endpackage

// File: rtl/rfsh_datapath.sv
module rfsh_datapath
  import rfsh_pkg::*;
#(
  parameter int REFI_NORM_CYC = 1560,
  parameter int REFI_HOT_CYC  = 780,
  parameter int RFC_CYC       = 52,
  parameter int MAX_POSTPONE  = 8,
  parameter int BURST_LIMIT   = 16,
  parameter int BUSY_REQ_LVL  = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hotMode,
  input  rfshStrobe_t strobe,
  output rfshStatus_t status,
  output logic        refUrgent,
  output logic        rfcBusy
);

  localparam int TIMER_W  = $clog2(REFI_NORM_CYC + 1);
  localparam int DEBT_MAX = MAX_POSTPONE + 1;
  localparam int DEBT_W   = $clog2(DEBT_MAX + 1);
  localparam int GAP_NORM = (2 * REFI_NORM_CYC + BURST_LIMIT - 1) / BURST_LIMIT;
  localparam int GAP_HOT  = (2 * REFI_HOT_CYC + BURST_LIMIT - 1) / BURST_LIMIT;
  localparam int GAP_W    = $clog2(GAP_NORM + 1);
  localparam int RFC_W    = $clog2(RFC_CYC + 1);

  localparam logic [TIMER_W-1:0] NORM_LAST = TIMER_W'(REFI_NORM_CYC - 1);
  localparam logic [TIMER_W-1:0] HOT_LAST  = TIMER_W'(REFI_HOT_CYC - 1);
  localparam logic [DEBT_W-1:0]  DEBT_TOP  = DEBT_W'(DEBT_MAX);
  localparam logic [DEBT_W-1:0]  URG_LVL   = DEBT_W'(MAX_POSTPONE);
  localparam logic [DEBT_W-1:0]  BUSY_LVL  = DEBT_W'(BUSY_REQ_LVL);
  localparam logic [GAP_W-1:0]   GAP_N_LD  = GAP_W'(GAP_NORM - 1);
  localparam logic [GAP_W-1:0]   GAP_H_LD  = GAP_W'(GAP_HOT - 1);
  localparam logic [RFC_W-1:0]   RFC_LD    = RFC_W'(RFC_CYC);

  logic [TIMER_W-1:0] intervalCnt;
  logic [DEBT_W-1:0]  debt;
  logic [GAP_W-1:0]   gapCnt;
  logic [RFC_W-1:0]   rfcCnt;
  logic               tick;
  logic [TIMER_W-1:0] refiLast;

  // Interval timer: counts up so a mode change applies at once
  assign refiLast = hotMode ? HOT_LAST : NORM_LAST;
  assign tick     = (intervalCnt >= refiLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     intervalCnt <= '0;
    else if (tick) intervalCnt <= '0;
    else           intervalCnt <= intervalCnt + 1'b1;
  end

  // Debt counter, saturating at DEBT_MAX
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      debt <= '0;
    end else begin
      unique case ({tick, strobe.issue})
        2'b10:   if (debt != DEBT_TOP) debt <= debt + 1'b1;
        2'b01:   if (debt != '0)       debt <= debt - 1'b1;
        default: debt <= debt;
      endcase
    end
  end

  // Pacing counter: minimum spacing between refreshes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              gapCnt <= '0;
    else if (strobe.issue)  gapCnt <= hotMode ? GAP_H_LD : GAP_N_LD;
    else if (gapCnt != '0)  gapCnt <= gapCnt - 1'b1;
  end

  // Recovery window counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              rfcCnt <= '0;
    else if (strobe.issue)  rfcCnt <= RFC_LD;
    else if (rfcCnt != '0)  rfcCnt <= rfcCnt - 1'b1;
  end

  assign rfcBusy   = (rfcCnt != '0);
  assign refUrgent = (debt >= URG_LVL);

  always_comb begin
    status.debtAny  = (debt != '0);
    status.debtBusy = (debt >= BUSY_LVL);
    status.urgent   = refUrgent;
    status.paceOk   = (gapCnt == '0);
    status.rfcIdle  = !rfcBusy;
  end

  // R9: a refresh is only taken against outstanding debt
  p_issue_has_debt_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issue |-> (debt != '0));

  // R9: debt climbs at most one per cycle and stays within its ceiling
  p_debt_step_r9: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (({1'b0, debt} <= ({1'b0, $past(debt)} + 1'b1)) && (debt <= DEBT_TOP)));

  // R7: pacing spacing has elapsed whenever a refresh is taken
  p_pace_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issue |-> (gapCnt == '0));

  // R6: recovery window opens after every refresh
  p_rfc_open_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issue |=> rfcBusy);

endmodule

// File: rtl/rfsh_control.sv
module rfsh_control
  import rfsh_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        arbIdle,
  input  logic        refGrant,
  input  rfshStatus_t status,
  output rfshStrobe_t strobe,
  output logic        refReq,
  output logic        refIssue
);

  rfshState_t state, stateNxt;
  logic       reqCond;

  // Idle arbiter: pay back any debt; busy arbiter: only at busy level or urgent
  assign reqCond = status.rfcIdle && status.paceOk && status.debtAny &&
                   (arbIdle || status.debtBusy || status.urgent);

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_WAIT: if (reqCond)  stateNxt = ST_REQ;
      ST_REQ:  if (refGrant) stateNxt = ST_WAIT;
      default: stateNxt = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_WAIT;
    else       state <= stateNxt;
  end

  assign refReq       = (state == ST_REQ);
  assign refIssue     = refReq && refGrant;
  assign strobe.issue = refIssue;

  // R5: an ungranted request is held
  p_hold_req_r5: assert property (@(posedge clk) disable iff (!rstN)
    (refReq && !refGrant) |=> refReq);

  // R6: no refresh while the recovery window is open
  p_quiet_rfc_r6: assert property (@(posedge clk) disable iff (!rstN)
    !status.rfcIdle |-> !refIssue);

endmodule

// File: rtl/dram_refresh_planner.sv
module dram_refresh_planner
  import rfsh_pkg::*;
#(
  parameter int REFI_NORM_CYC = 1560,
  parameter int REFI_HOT_CYC  = 780,
  parameter int RFC_CYC       = 52,
  parameter int MAX_POSTPONE  = 8,
  parameter int BURST_LIMIT   = 16,
  parameter int BUSY_REQ_LVL  = 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic hotMode,
  input  logic arbIdle,
  input  logic refGrant,
  output logic refReq,
  output logic refUrgent,
  output logic refIssue,
  output logic rfcBusy
);

  rfshStrobe_t strobe;
  rfshStatus_t status;

  rfsh_datapath #(
    .REFI_NORM_CYC(REFI_NORM_CYC),
    .REFI_HOT_CYC (REFI_HOT_CYC),
    .RFC_CYC      (RFC_CYC),
    .MAX_POSTPONE (MAX_POSTPONE),
    .BURST_LIMIT  (BURST_LIMIT),
    .BUSY_REQ_LVL (BUSY_REQ_LVL)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .hotMode  (hotMode),
    .strobe   (strobe),
    .status   (status),
    .refUrgent(refUrgent),
    .rfcBusy  (rfcBusy)
  );

  rfsh_control ctl_i (
    .clk     (clk),
    .rstN    (rstN),
    .arbIdle (arbIdle),
    .refGrant(refGrant),
    .status  (status),
    .strobe  (strobe),
    .refReq  (refReq),
    .refIssue(refIssue)
  );

endmodule

// File: tb/dram_refresh_planner_tb_top.sv
`timescale 1ns/1ps
module dram_refresh_planner_tb_top;

  localparam int REFI  = 64;
  localparam int HOT   = 32;
  localparam int RFC   = 5;
  localparam int POST  = 8;
  localparam int BURST = 16;
  localparam int BUSYL = 3;
  localparam int GAP   = (2 * REFI + BURST - 1) / BURST;

  logic clk = 1'b0;
  logic rstN, hotMode, arbIdle, refGrant;
  logic refReq, refUrgent, refIssue, rfcBusy;
  int   checks = 0;
  int   errors = 0;

  always #2.5 clk = ~clk;

  dram_refresh_planner #(
    .REFI_NORM_CYC(REFI), .REFI_HOT_CYC(HOT), .RFC_CYC(RFC),
    .MAX_POSTPONE(POST), .BURST_LIMIT(BURST), .BUSY_REQ_LVL(BUSYL)
  ) dut_i (
    .clk(clk), .rstN(rstN), .hotMode(hotMode), .arbIdle(arbIdle),
    .refGrant(refGrant), .refReq(refReq), .refUrgent(refUrgent),
    .refIssue(refIssue), .rfcBusy(rfcBusy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic stepN(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R1: reset state, then release at a falling edge
  task automatic doReset(input logic hot, input logic idle);
    @(negedge clk);
    rstN = 1'b0; hotMode = hot; arbIdle = idle; refGrant = 1'b0;
    stepN(3);
    check({refReq, refUrgent, refIssue, rfcBusy} == 4'b0, "R1 in reset",
          {refReq, refUrgent, refIssue, rfcBusy}, 0);
    rstN = 1'b1;
    stepN(1);
    check({refReq, refUrgent, refIssue, rfcBusy} == 4'b0, "R1 after release",
          {refReq, refUrgent, refIssue, rfcBusy}, 0);
  endtask

  // Edges after release until refReq first reads 1 (one edge already taken)
  task automatic firstReq(output int n);
    n = 1;
    while (!refReq && n < 20 * REFI) begin
      stepN(1);
      n++;
    end
  endtask

  task automatic testNormalTick();
    int n;
    doReset(1'b0, 1'b1);
    firstReq(n);
    check(n == REFI + 1, "R2 normal interval", n, REFI + 1);
  endtask

  task automatic testHotTick();
    int n;
    doReset(1'b1, 1'b1);
    firstReq(n);
    check(n == HOT + 1, "R3 hot interval", n, HOT + 1);
  endtask

  task automatic testHandshake();
    bit held = 1'b1;
    bit stray = 1'b0;
    doReset(1'b0, 1'b1);
    stepN(REFI);                   // now edge REFI+1: request up
    check(refReq == 1'b1, "R5 request raised", refReq, 1);
    for (int i = 0; i < 20; i++) begin
      stepN(1);
      if (!refReq || refIssue) held = 1'b0;
    end
    check(held, "R5 request held without grant", held, 1);
    refGrant = 1'b1;
    #1;
    check(refIssue == 1'b1, "R5 issue on grant", refIssue, 1);
    stepN(1);
    check(refReq == 1'b0, "R5 request drops after refresh", refReq, 0);
    check(rfcBusy == 1'b1, "R6 busy after refresh", rfcBusy, 1);
    for (int i = 0; i < 15; i++) begin   // debt is zero: grant must be ignored
      stepN(1);
      if (refIssue || refReq) stray = 1'b1;
    end
    check(!stray, "R5 grant without request ignored", stray, 0);
    refGrant = 1'b0;
  endtask

  task automatic testBusyAndUrgent();
    doReset(1'b0, 1'b0);
    stepN(3 * REFI - 1);           // edge 3*REFI
    check(refReq == 1'b0, "R4 busy below level", refReq, 0);
    stepN(1);
    check(refReq == 1'b1, "R4 busy level reached", refReq, 1);
    stepN(8 * REFI - 3 * REFI - 2);  // edge 8*REFI-1
    check(refUrgent == 1'b0, "R8 not urgent at 7", refUrgent, 0);
    stepN(1);
    check(refUrgent == 1'b1, "R8 urgent at limit", refUrgent, 1);
    refGrant = 1'b1;
    #1;
    check(refIssue == 1'b1, "R8 urgent refresh taken", refIssue, 1);
    stepN(1);
    refGrant = 1'b0;
    check(refUrgent == 1'b0, "R8 urgent clears", refUrgent, 0);
  endtask

  // R9 saturation, R6 window length, R7 pacing during backlog repayment
  task automatic testSaturation();
    int issues = 0;
    int lastIss = -1;
    int minGap = 1000;
    int run = 0;
    int badRuns = 0;
    int overlap = 0;
    doReset(1'b0, 1'b1);
    stepN(12 * REFI);              // edge 12*REFI+1; debt would be 12 unsaturated
    refGrant = 1'b1;
    for (int i = 0; i < 119; i++) begin
      #1;
      if (refIssue) begin
        issues++;
        if (rfcBusy) overlap++;
        if (lastIss >= 0 && (i - lastIss) < minGap) minGap = i - lastIss;
        lastIss = i;
      end
      if (rfcBusy) run++;
      else if (run != 0) begin
        if (run != RFC) badRuns++;
        run = 0;
      end
      stepN(1);
    end
    refGrant = 1'b0;
    #1;
    // 9 saturated units plus one tick during repayment
    check(issues == POST + 2, "R9 saturated debt repaid", issues, POST + 2);
    check(minGap >= GAP, "R7 pacing spacing", minGap, GAP);
    check(badRuns == 0, "R6 window length", badRuns, 0);
    check(overlap == 0, "R6 no refresh in window", overlap, 0);
    check(refReq == 1'b0, "R9 debt cleared", refReq, 0);
  endtask

  initial begin
    rstN = 1'b0; hotMode = 1'b0; arbIdle = 1'b0; refGrant = 1'b0;
    testNormalTick();
    testHotTick();
    testHandshake();
    testBusyAndUrgent();
    testSaturation();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule